// File: doc/BRIEF.md
# Expansion Bus Burst Master Engine

This block is the engine that moves blocks of words while an expansion-bus host port acts as bus master. The processor loads a word address for on-chip memory and a word address for the external bus, then writes a control word that carries a two-bit start code, a word count and an interrupt-source select. Code 01 copies words from on-chip memory out to the external bus. Code 10 copies words from the external bus into on-chip memory.

Before the first beat the engine asks an arbiter for the bus with a hold request and waits for the acknowledge. Each beat then waits on a ready input, and the last beat is flagged. Both addresses step by one word for each accepted beat and the count steps down by one, until the count reaches zero. If the back-off input is asserted, the engine gives the bus up, keeps its place, asks again and carries on. A one-cycle interrupt is raised either when a burst finishes or when an external master rings a doorbell input, whichever source is selected.

On-chip memory is reached through a simple port with one cycle of read latency. The external bus has separate address, write-data and read-data lines, a write flag, byte enables, a beat-valid strobe, a last-beat flag and a ready input.

Top module: `xbm_burst_engine`

## Requirements
- R1: A write with cfg_sel=0 loads the control word: bits [1:0] hold the start code, bit 4 the interrupt select and bits [31:16] the count. cfg_sel=1 loads the on-chip address and cfg_sel=2 loads the external address, both taken from the low bits. st_start reads 00 while idle and shows the running code while a burst is active. st_count, st_int_addr and st_ext_addr show the live count and addresses.
- R2: Start code 01 with a count N greater than 0 writes the N words at on-chip addresses A, A+1, … to external addresses B, B+1, …, with xb_wr=1 and xb_be all ones. No other external word changes.
- R3: Start code 10 with a count N greater than 0 reads external words B, B+1, … and writes them to on-chip addresses A, A+1, …. No other on-chip word changes.
- R4: Each accepted beat (xb_valid and xb_rdy at a rising edge) lowers the count by one and raises both addresses by one. After a burst the count reads 0 and the addresses read A+N and B+N.
- R5: xb_last is high only during the final beat of a burst. After that beat is accepted the engine returns to idle and drops xb_hold.
- R6: xb_hold rises before any beat, and no beat is driven before xb_holda is seen. xb_valid is high only while xb_hold is high.
- R7: While a beat waits for xb_rdy, its address, write flag and write data hold steady.
- R8: When xb_boff is high, xb_hold falls at the next edge. The engine waits for xb_boff and xb_holda to both be low, requests the bus again and resumes at the same word. No word is lost or repeated.
- R9: Every configuration write made while a burst is active is ignored.
- R10: Start codes 00 and 11, and any start with count 0, start no burst and raise no hold. The count and interrupt select are still loaded.
- R11: With select 0, xb_irq pulses for one cycle, one cycle after the final beat is accepted, and a doorbell has no effect. With select 1, xb_irq pulses one cycle after a db_set pulse, and a finished burst has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | 0 control, 1 on-chip address, 2 external address |
| cfg_wdata | input | 32 | Configuration write data |
| st_start | output | 2 | Active start code, 00 when idle |
| st_count | output | CW | Remaining word count |
| st_int_addr | output | AW | Current on-chip word address |
| st_ext_addr | output | AW | Current external word address |
| db_set | input | 1 | Doorbell pulse from an external master |
| xb_irq | output | 1 | Interrupt pulse to the processor |
| im_rd | output | 1 | On-chip read request (data valid the next cycle) |
| im_wr | output | 1 | On-chip write strobe |
| im_addr | output | AW | On-chip word address |
| im_wdata | output | DW | On-chip write data |
| im_rdata | input | DW | On-chip read data |
| xb_hold | output | 1 | Bus request to the arbiter |
| xb_holda | input | 1 | Bus grant from the arbiter |
| xb_boff | input | 1 | Back-off: give up the bus |
| xb_valid | output | 1 | Beat valid |
| xb_wr | output | 1 | 1 = write to the external bus |
| xb_addr | output | AW | External word address |
| xb_wdata | output | DW | External write data |
| xb_rdata | input | DW | External read data |
| xb_be | output | DW/8 | Byte enables |
| xb_last | output | 1 | Final beat of the burst |
| xb_rdy | input | 1 | Beat accepted |

## Verification
The bench sweeps both directions over counts one to six and ready delays of zero to two cycles, then checks the words next to each burst. An engine with an off-by-one in its count would spill into those words or stop one short. It would also flag the wrong beat as last. A back-off raised partway through a burst checks that the engine resumes at the same word: a design that advanced early would skip a word, and one that re-fetched badly would repeat one. Start writes made mid-burst, unused codes, zero counts and both interrupt selects are all tried. A design that let a late write restart the burst would corrupt memory or the count, and one that routed the wrong interrupt source would change the pulse count.

// File: rtl/xbm_burst_engine.sv
module xbm_burst_engine #(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic [1:0]    cfg_sel,
  input  logic [31:0]   cfg_wdata,
  output logic [1:0]    st_start,
  output logic [CW-1:0] st_count,
  output logic [AW-1:0] st_int_addr,
  output logic [AW-1:0] st_ext_addr,
  input  logic          db_set,
  output logic          xb_irq,
  output logic          im_rd,
  output logic          im_wr,
  output logic [AW-1:0] im_addr,
  output logic [DW-1:0] im_wdata,
  input  logic [DW-1:0] im_rdata,
  output logic          xb_hold,
  input  logic          xb_holda,
  input  logic          xb_boff,
  output logic          xb_valid,
  output logic          xb_wr,
  output logic [AW-1:0] xb_addr,
  output logic [DW-1:0] xb_wdata,
  input  logic [DW-1:0] xb_rdata,
  output logic [DW/8-1:0] xb_be,
  output logic          xb_last,
  input  logic          xb_rdy
);
  localparam logic [1:0] CODE_OUT = 2'b01;
  localparam logic [1:0] CODE_IN  = 2'b10;
  localparam int CNT_LSB = 16;

  typedef enum logic [2:0] {S_IDLE, S_REQ, S_FETCH, S_LOAD, S_BEAT, S_BACK} state_t;

  state_t        st;
  logic [1:0]    mode;
  logic          isrc;
  logic [CW-1:0] cnt;
  logic [AW-1:0] ia, ea;
  logic [DW-1:0] wbuf;

  logic [1:0] new_code;
  logic [CW-1:0] new_cnt;
  logic go, is_out, beat_done, done_evt;

  assign new_code  = cfg_wdata[1:0];
  assign new_cnt   = cfg_wdata[CNT_LSB +: CW];
  assign go        = (new_code == CODE_OUT || new_code == CODE_IN) && new_cnt != '0;
  assign is_out    = mode == CODE_OUT;
  assign beat_done = st == S_BEAT && xb_rdy;
  assign done_evt  = beat_done && cnt == CW'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      mode   <= 2'b00;
      isrc   <= 1'b0;
      cnt    <= '0;
      ia     <= '0;
      ea     <= '0;
      wbuf   <= '0;
      xb_irq <= 1'b0;
    end else begin
      xb_irq <= isrc ? db_set : done_evt;
      case (st)
        S_IDLE: if (cfg_wr) begin
          case (cfg_sel)
            2'd0: begin
              isrc <= cfg_wdata[4];
              cnt  <= new_cnt;
              if (go) begin
                mode <= new_code;
                st   <= S_REQ;
              end
            end
            2'd1: ia <= cfg_wdata[AW-1:0];
            2'd2: ea <= cfg_wdata[AW-1:0];
            default: ;
          endcase
        end
        S_REQ: begin
          if (xb_boff) st <= S_BACK;
          else if (xb_holda) st <= is_out ? S_FETCH : S_BEAT;
        end
        S_FETCH: st <= xb_boff ? S_BACK : S_LOAD;
        S_LOAD: begin
          wbuf <= im_rdata;
          st   <= xb_boff ? S_BACK : S_BEAT;
        end
        S_BEAT: begin
          if (xb_rdy) begin
            ia  <= ia + AW'(1);
            ea  <= ea + AW'(1);
            cnt <= cnt - CW'(1);
            if (cnt == CW'(1)) st <= S_IDLE;
            else if (xb_boff) st <= S_BACK;
            else st <= is_out ? S_FETCH : S_BEAT;
          end else if (xb_boff) begin
            st <= S_BACK;
          end
        end
        S_BACK: if (!xb_boff && !xb_holda) st <= S_REQ;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign st_start    = (st == S_IDLE) ? 2'b00 : mode;
  assign st_count    = cnt;
  assign st_int_addr = ia;
  assign st_ext_addr = ea;

  assign xb_hold  = st == S_REQ || st == S_FETCH || st == S_LOAD || st == S_BEAT;
  assign xb_valid = st == S_BEAT;
  assign xb_wr    = is_out;
  assign xb_addr  = ea;
  assign xb_wdata = wbuf;
  assign xb_be    = '1;
  assign xb_last  = xb_valid && cnt == CW'(1);

  assign im_rd    = st == S_FETCH;
  assign im_wr    = beat_done && !is_out;
  assign im_addr  = ia;
  assign im_wdata = xb_rdata;
endmodule

module xbm_burst_engine_chk #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    st_start,
  input logic [CW-1:0] st_count,
  input logic [AW-1:0] st_ext_addr,
  input logic          xb_hold,
  input logic          xb_boff,
  input logic          xb_valid,
  input logic          xb_wr,
  input logic [AW-1:0] xb_addr,
  input logic          xb_last,
  input logic          xb_rdy
);
  assert_valid_needs_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    xb_valid |-> xb_hold);

  assert_last_inside_beat_R5: assert property (@(posedge clk) disable iff (!rst_n)
    xb_last |-> xb_valid);

  assert_idle_after_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
    xb_valid && xb_rdy && xb_last |=> st_start == 2'b00 && !xb_hold);

  assert_beat_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    xb_valid && !xb_rdy && !xb_boff |=> xb_valid && $stable(xb_addr) && $stable(xb_wr));

  assert_boff_releases_R8: assert property (@(posedge clk) disable iff (!rst_n)
    xb_hold && xb_boff |=> !xb_hold);

  assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    xb_valid && xb_rdy |=> st_count == $past(st_count) - CW'(1));

  assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    xb_valid && xb_rdy |=> st_ext_addr == $past(st_ext_addr) + AW'(1));
endmodule

bind xbm_burst_engine xbm_burst_engine_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .st_start(st_start), .st_count(st_count),
  .st_ext_addr(st_ext_addr), .xb_hold(xb_hold), .xb_boff(xb_boff),
  .xb_valid(xb_valid), .xb_wr(xb_wr), .xb_addr(xb_addr),
  .xb_last(xb_last), .xb_rdy(xb_rdy)
);

// File: tb/xbm_burst_engine_bench.sv
module xbm_burst_engine_bench;
  localparam int AW = 16, DW = 32, CW = 16;

  logic clk = 0, rst_n = 0;
  logic cfg_wr = 0;
  logic [1:0] cfg_sel = 0;
  logic [31:0] cfg_wdata = 0;
  logic [1:0] st_start;
  logic [CW-1:0] st_count;
  logic [AW-1:0] st_int_addr, st_ext_addr;
  logic db_set = 0, xb_irq;
  logic im_rd, im_wr;
  logic [AW-1:0] im_addr;
  logic [DW-1:0] im_wdata, im_rdata;
  logic xb_hold, xb_holda, xb_boff = 0;
  logic xb_valid, xb_wr, xb_last, xb_rdy;
  logic [AW-1:0] xb_addr;
  logic [DW-1:0] xb_wdata, xb_rdata;
  logic [DW/8-1:0] xb_be;

  always #4 clk = ~clk;

  xbm_burst_engine #(.AW(AW), .DW(DW), .CW(CW)) u_xbm_burst_engine (.*);

  logic [DW-1:0] int_mem [64];
  logic [DW-1:0] ext_mem [64];
  int ws = 0, wc = 0;
  int checks = 0, failures = 0;
  int irq_cnt = 0, beats = 0, cur_n = 0, boff_left = 0, boff_hits = 0, boff_beat = 0;
  bit boff_arm = 0;

  function automatic logic [31:0] int_init(int i); return 32'hA500_0000 + i * 32'h0101; endfunction
  function automatic logic [31:0] ext_init(int i); return 32'h3C00_0000 ^ (i * 32'h11); endfunction
  function automatic logic [31:0] ctrl(logic [1:0] c, int n, bit s);
    return {n[15:0], 11'd0, s, 2'd0, c};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) xb_holda <= 0; else xb_holda <= xb_hold;
    if (im_rd) im_rdata <= int_mem[im_addr[5:0]];
    if (im_wr) int_mem[im_addr[5:0]] <= im_wdata;
  end

  assign xb_rdata = ext_mem[xb_addr[5:0]];

  always @(posedge clk) begin
    if (!rst_n || !xb_valid) begin xb_rdy <= 0; wc <= 0; end
    else if (xb_rdy) begin
      xb_rdy <= 0; wc <= 0;
      if (xb_wr) ext_mem[xb_addr[5:0]] <= xb_wdata;
    end else if (wc >= ws) xb_rdy <= 1;
    else wc <= wc + 1;
  end

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (xb_irq) irq_cnt++;
    if (xb_valid && xb_rdy) begin
      chk(xb_last == (beats == cur_n - 1), "R5", "last flag", 32'(xb_last), 32'(beats == cur_n - 1));
      beats++;
    end
    if (boff_left != 0) begin
      boff_left--;
      xb_boff <= boff_left > 0;
    end else if (boff_arm && xb_valid && !xb_rdy && beats == boff_beat) begin
      xb_boff <= 1; boff_left = 3; boff_arm = 0; boff_hits++;
    end
  end

  task automatic cfg(logic [1:0] sel, logic [31:0] d);
    @(negedge clk); cfg_wr = 1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk); cfg_wr = 0;
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 5000 && st_start != 2'b00; k++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic init_mems();
    for (int i = 0; i < 64; i++) begin int_mem[i] = int_init(i); ext_mem[i] = ext_init(i); end
  endtask

  task automatic burst(logic [1:0] code, int n, int ia, int ea, bit s, int w, int bo);
    int irq0, bh0;
    string rq;
    init_mems();
    ws = w; cur_n = n; beats = 0; irq0 = irq_cnt; bh0 = boff_hits;
    boff_arm = bo >= 0; boff_beat = bo;
    rq = (code == 2'b01) ? "R2" : "R3";
    cfg(2'd1, 32'(ia)); cfg(2'd2, 32'(ea)); cfg(2'd0, ctrl(code, n, s));
    wait_idle();
    chk(beats == n, rq, "beat count", 32'(beats), 32'(n));
    chk(st_count == 0, "R4", "final count", 32'(st_count), 0);
    chk(st_int_addr == AW'(ia + n), "R4", "int addr", 32'(st_int_addr), 32'(ia + n));
    chk(st_ext_addr == AW'(ea + n), "R4", "ext addr", 32'(st_ext_addr), 32'(ea + n));
    for (int i = 0; i < n; i++) begin
      if (code == 2'b01) chk(ext_mem[ea+i] == int_init(ia+i), "R2", "ext word", ext_mem[ea+i], int_init(ia+i));
      else chk(int_mem[ia+i] == ext_init(ea+i), "R3", "int word", int_mem[ia+i], ext_init(ea+i));
    end
    if (code == 2'b01) chk(ext_mem[ea+n] == ext_init(ea+n), "R2", "word past end", ext_mem[ea+n], ext_init(ea+n));
    else chk(int_mem[ia+n] == int_init(ia+n), "R3", "word past end", int_mem[ia+n], int_init(ia+n));
    chk(irq_cnt - irq0 == (s ? 0 : 1), "R11", "irq pulses", 32'(irq_cnt - irq0), s ? 0 : 1);
    if (bo >= 0) chk(boff_hits - bh0 == 1, "R8", "back-off applied", 32'(boff_hits - bh0), 1);
    boff_arm = 0;
  endtask

  initial begin
    for (int c = 0; c < 200000; c++) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int irq0;
    init_mems();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(st_start == 0, "R1", "reset start", 32'(st_start), 0);
    chk(!xb_hold && !xb_valid && !xb_irq, "R6", "reset bus idle", 32'({xb_hold, xb_valid, xb_irq}), 0);
    chk(st_count == 0, "R1", "reset count", 32'(st_count), 0);

    for (int c = 1; c <= 2; c++)
      for (int n = 1; n <= 6; n++)
        for (int w = 0; w <= 2; w++)
          burst(2'(c), n, n + w, 32 + 2 * w + c, 0, w, -1);

    burst(2'b01, 6, 4, 40, 0, 1, 2);
    burst(2'b10, 6, 10, 20, 0, 0, 3);
    burst(2'b01, 5, 1, 50, 0, 2, 0);

    // R9: configuration writes during a burst
    init_mems(); ws = 2; cur_n = 5; beats = 0;
    cfg(2'd1, 32'd3); cfg(2'd2, 32'd30); cfg(2'd0, ctrl(2'b01, 5, 0));
    repeat (2) @(negedge clk);
    chk(st_start == 2'b01, "R1", "busy readback", 32'(st_start), 1);
    cfg(2'd0, ctrl(2'b10, 9, 1)); cfg(2'd2, 32'd0);
    wait_idle();
    chk(beats == 5, "R9", "beats after busy write", 32'(beats), 5);
    chk(st_ext_addr == 35, "R9", "ext addr after busy write", 32'(st_ext_addr), 35);
    chk(ext_mem[34] == int_init(7), "R9", "last word", ext_mem[34], int_init(7));
    chk(ext_mem[0] == ext_init(0), "R9", "untouched word", ext_mem[0], ext_init(0));

    // R10: codes that start nothing
    beats = 0; irq0 = irq_cnt;
    cfg(2'd0, ctrl(2'b11, 3, 0)); repeat (6) @(negedge clk);
    chk(st_start == 0 && !xb_hold, "R10", "code 11 idle", 32'({st_start, xb_hold}), 0);
    chk(st_count == 3, "R10", "count loaded", 32'(st_count), 3);
    cfg(2'd0, ctrl(2'b00, 4, 0)); repeat (6) @(negedge clk);
    chk(st_start == 0 && !xb_hold, "R10", "code 00 idle", 32'({st_start, xb_hold}), 0);
    cfg(2'd0, ctrl(2'b01, 0, 0)); repeat (6) @(negedge clk);
    chk(st_start == 0 && !xb_hold, "R10", "zero count idle", 32'({st_start, xb_hold}), 0);
    chk(beats == 0 && irq_cnt == irq0, "R10", "no beats or irq", 32'(beats + irq_cnt - irq0), 0);

    // R11: interrupt source select
    burst(2'b01, 3, 2, 12, 1, 0, -1);
    irq0 = irq_cnt;
    @(negedge clk); db_set = 1; @(negedge clk); db_set = 0; repeat (2) @(negedge clk);
    chk(irq_cnt - irq0 == 1, "R11", "doorbell select 1", 32'(irq_cnt - irq0), 1);
    cfg(2'd0, ctrl(2'b00, 0, 0));
    irq0 = irq_cnt;
    @(negedge clk); db_set = 1; @(negedge clk); db_set = 0; repeat (2) @(negedge clk);
    chk(irq_cnt == irq0, "R11", "doorbell select 0", 32'(irq_cnt - irq0), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule